// File: doc/BRIEF.md
# Pulse-Order Clock and Data Recovery Decoder

This block sits behind the two threshold detectors of a three-level serial line. Each detector gives an active-low pulse line. A line bit is carried as an ordered pair of pulses. When the high-threshold line fires first and the low-threshold line second, the bit is a one. When the order is reversed, the bit is a zero. The decoder watches the order of the pulses and rebuilds the serial bit and a bit clock from that order alone, so it needs no phase-locked loop and no oversampling recovery loop.

The pulse lines are sampled on a local clock that is fast enough to see every pulse. Each line is edge-detected, so a pulse that lasts several samples is one event. A three-state order detector holds one of three states: idle, waiting after a high-line pulse, or waiting after a low-line pulse. It drives a set/clear data latch and a recovered bit clock. The bit clock is high while a pair is half received. Each completed pair shifts one bit into a deserializer. After every eighth bit, the deserializer presents a parallel word with a one-cycle strobe. The first bit received lands in the MSB.

Top module: `pulse_order_cdr`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bitClk`, `serialBit`, `wordValid` and `wordOut` are all 0.
- R2: In the idle state, a falling edge on `pulseHiN` with no falling edge on `pulseLoN` makes `bitClk` and `serialBit` 1 from the next clock edge. A later falling edge on `pulseLoN` completes a 1 bit and returns `bitClk` to 0 at the edge that samples it.
- R3: In the idle state, a falling edge on `pulseLoN` alone makes `bitClk` 1 and `serialBit` 0 from the next edge. A later falling edge on `pulseHiN` completes a 0 bit.
- R4: While the detector waits for the second pulse, another falling edge on the line that started the bit is ignored. `bitClk` and `serialBit` keep their values, and no bit is counted.
- R5: A pulse that stays low for several samples is one event. Only the high-to-low transition counts.
- R6: In the idle state, falling edges on both lines in the same sample are ignored. `bitClk` stays 0, `serialBit` is unchanged, and no bit is counted.
- R7: `wordValid` is high for exactly one cycle, at the edge that completes every 8th bit. On that edge `wordOut` holds the 8 bits with the earliest received bit in bit 7.
- R8: `bitClk` rises once per bit, when the first pulse of a pair is sampled. It falls when the pair completes.
- R9: A synchronous `rst` asserted in the middle of a word returns the detector to idle and clears the bit count. The next 8 bits form a complete word.
- R10: While the detector waits after a `pulseHiN` event, falling edges on both lines in one sample complete a 1 bit. The repeated high-line edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pulseHiN | input | 1 | Active-low pulse from the upper-threshold detector |
| pulseLoN | input | 1 | Active-low pulse from the lower-threshold detector |
| serialBit | output | 1 | Recovered data latch |
| bitClk | output | 1 | Recovered bit clock, high while a pulse pair is open |
| wordOut | output | 8 | Deserialized word, first bit in MSB |
| wordValid | output | 1 | One-cycle strobe for a new word |

## Verification
Two functions can meet in one cycle. The first is the word strobe for the 8th bit. The second is the start of the next bit when its opening pulse falls in the very next sample. The bench provokes this by releasing the closing line and dropping the next opening line on the cycle right after the 8th completion. It then checks that `wordValid` falls while `bitClk` rises, and that the new bit is counted in the following word. The other collision is two falling edges in one sample. The bench drives this once from idle, where it must be dropped, and once mid-pair, where it must close the bit. In both cases the result is judged through `bitClk`, `serialBit` and the next word.

// File: rtl/pulse_order_pkg.sv
package pulse_order_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HI_OPEN = 2'd1,
    ST_LO_OPEN = 2'd2
  } detState_t;

  typedef struct packed {
    logic setData;
    logic clrData;
    logic shiftEn;
    logic shiftBit;
    logic wordDone;
  } ctlStrobe_t;

endpackage

// File: rtl/pulse_order_ctrl.sv
module pulse_order_ctrl
  import pulse_order_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pulseHiN,
  input  logic       pulseLoN,
  output logic       bitClk,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic hiPrev, loPrev;
  logic hiEvt, loEvt;
  detState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt;

  // previous samples of the pulse lines; forced high in reset
  always_ff @(posedge clk) begin
    if (rst) begin
      hiPrev <= 1'b1;
      loPrev <= 1'b1;
    end else begin
      hiPrev <= pulseHiN;
      loPrev <= pulseLoN;
    end
  end

  assign hiEvt = hiPrev & ~pulseHiN;
  assign loEvt = loPrev & ~pulseLoN;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (hiEvt && !loEvt) begin
          stateNext      = ST_HI_OPEN;
          strobe.setData = 1'b1;
        end else if (loEvt && !hiEvt) begin
          stateNext      = ST_LO_OPEN;
          strobe.clrData = 1'b1;
        end
      end
      ST_HI_OPEN: begin
        if (loEvt) begin
          stateNext       = ST_IDLE;
          strobe.shiftEn  = 1'b1;
          strobe.shiftBit = 1'b1;
        end
      end
      ST_LO_OPEN: begin
        if (hiEvt) begin
          stateNext       = ST_IDLE;
          strobe.shiftEn  = 1'b1;
          strobe.shiftBit = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    strobe.wordDone = strobe.shiftEn && (bitCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.wordDone)     bitCnt <= '0;
      else if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign bitClk = (state != ST_IDLE);

endmodule

// File: rtl/pulse_order_dpath.sv
module pulse_order_dpath
  import pulse_order_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  output logic              serialBit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[WORD_W-2:0], strobe.shiftBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      serialBit <= 1'b0;
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      if (strobe.setData)      serialBit <= 1'b1;
      else if (strobe.clrData) serialBit <= 1'b0;
      if (strobe.shiftEn) shiftReg <= shiftNext;
      if (strobe.wordDone) wordOut <= shiftNext;
      wordValid <= strobe.wordDone;
    end
  end

endmodule

// File: rtl/pulse_order_cdr.sv
module pulse_order_cdr
  import pulse_order_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulseHiN,
  input  logic              pulseLoN,
  output logic              serialBit,
  output logic              bitClk,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  ctlStrobe_t strobe;

  pulse_order_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .pulseHiN (pulseHiN),
    .pulseLoN (pulseLoN),
    .bitClk   (bitClk),
    .strobe   (strobe)
  );

  pulse_order_dpath #(.WORD_W(WORD_W)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .serialBit (serialBit),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

endmodule

// File: rtl/pulse_order_cdr_chk.sv
module pulse_order_cdr_chk (
  input logic clk,
  input logic rst,
  input logic pulseHiN,
  input logic pulseLoN,
  input logic serialBit,
  input logic bitClk,
  input logic wordValid
);

  assert_hi_first_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !bitClk && $fell(pulseHiN) && !$fell(pulseLoN)) |=> (bitClk && serialBit));

  assert_lo_first_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !bitClk && $fell(pulseLoN) && !$fell(pulseHiN)) |=> (bitClk && !serialBit));

  assert_repeat_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bitClk && serialBit && $fell(pulseHiN) && !$fell(pulseLoN)) |=> (bitClk && serialBit));

  assert_both_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !bitClk && $fell(pulseHiN) && $fell(pulseLoN)) |=> (!bitClk && $stable(serialBit)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  assert_valid_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wordValid) |-> $fell(bitClk));

endmodule

bind pulse_order_cdr pulse_order_cdr_chk uChk (
  .clk       (clk),
  .rst       (rst),
  .pulseHiN  (pulseHiN),
  .pulseLoN  (pulseLoN),
  .serialBit (serialBit),
  .bitClk    (bitClk),
  .wordValid (wordValid)
);

// File: tb/pulse_order_cdr_test.sv
module pulse_order_cdr_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hiN = 1'b1;
  logic loN = 1'b1;
  logic serialBit, bitClk, wordValid;
  logic [7:0] wordOut;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pulse_order_cdr uut (
    .clk       (clk),
    .rst       (rst),
    .pulseHiN  (hiN),
    .pulseLoN  (loN),
    .serialBit (serialBit),
    .bitClk    (bitClk),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );

  // {word, pulse width, gap after bit}
  localparam logic [15:0] VEC [6] = '{
    {8'hA5, 4'd1, 4'd1},
    {8'h00, 4'd2, 4'd0},
    {8'hFF, 4'd3, 4'd2},
    {8'h3C, 4'd1, 4'd0},
    {8'h81, 4'd5, 4'd1},
    {8'h5A, 4'd2, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input bit b, input int width, input bit last, input logic [7:0] expWord);
    @(negedge clk);
    if (b) hiN = 1'b0; else loN = 1'b0;
    @(negedge clk);
    chk(bitClk == 1'b1, "R8 bitClk rise", 32'(bitClk), 1);
    chk(serialBit == b, b ? "R2 data one" : "R3 data zero", 32'(serialBit), 32'(b));
    repeat (width - 1) @(negedge clk);
    chk(bitClk == 1'b1, "R5 long pulse holds open", 32'(bitClk), 1);
    if (b) hiN = 1'b1; else loN = 1'b1;
    @(negedge clk);
    if (b) loN = 1'b0; else hiN = 1'b0;
    @(negedge clk);
    chk(bitClk == 1'b0, "R8 bitClk fall", 32'(bitClk), 0);
    chk(wordValid == last, "R7 valid strobe", 32'(wordValid), 32'(last));
    if (last) chk(wordOut == expWord, "R7 word MSB first", 32'(wordOut), 32'(expWord));
    @(negedge clk);
    chk(wordValid == 1'b0, "R7 valid one cycle", 32'(wordValid), 0);
    repeat (width) @(negedge clk);
    hiN = 1'b1;
    loN = 1'b1;
  endtask

  task automatic sendWord(input logic [7:0] w, input int width, input int gap);
    for (int i = 7; i >= 0; i--) begin
      sendBit(w[i], width, i == 0, w);
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic keep;
    repeat (3) @(negedge clk);
    chk(bitClk == 0 && serialBit == 0 && wordValid == 0 && wordOut == 0, "R1 reset state",
        {bitClk, serialBit, wordValid, wordOut}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bitClk == 0 && wordValid == 0, "R1 after reset", {bitClk, wordValid}, 0);

    // table walk: R2 R3 R5 R7 R8
    for (int v = 0; v < 6; v++)
      sendWord(VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));

    // R4: repeated high-line pulse while open
    @(negedge clk); hiN = 1'b0;
    @(negedge clk); hiN = 1'b1;
    @(negedge clk); hiN = 1'b0;
    @(negedge clk);
    chk(bitClk == 1 && serialBit == 1, "R4 repeat ignored", {bitClk, serialBit}, 2'b11);
    hiN = 1'b1;
    @(negedge clk); loN = 1'b0;
    @(negedge clk); loN = 1'b1;
    chk(bitClk == 0, "R4 pair closes", 32'(bitClk), 0);
    for (int i = 6; i >= 0; i--) sendBit(1'(8'h9B >> i), 1, i == 0, 8'h9B);

    // R6: both lines fall together while idle
    keep = serialBit;
    @(negedge clk); hiN = 1'b0; loN = 1'b0;
    @(negedge clk);
    chk(bitClk == 0 && serialBit == keep, "R6 simultaneous idle ignored", {bitClk, serialBit}, {1'b0, keep});
    hiN = 1'b1; loN = 1'b1;
    @(negedge clk);
    chk(bitClk == 0, "R6 stays idle", 32'(bitClk), 0);
    sendWord(8'h47, 1, 0);

    // R10: both fall while a high-first pair is open
    @(negedge clk); hiN = 1'b0;
    @(negedge clk); hiN = 1'b1;
    @(negedge clk); hiN = 1'b0; loN = 1'b0;
    @(negedge clk);
    chk(bitClk == 0 && serialBit == 1, "R10 closes one", {bitClk, serialBit}, 2'b01);
    hiN = 1'b1; loN = 1'b1;
    for (int i = 6; i >= 0; i--) sendBit(1'(8'hB3 >> i), 2, i == 0, 8'hB3);

    // back-to-back: word strobe and next bit start collide
    for (int i = 7; i >= 1; i--) sendBit(1'(8'hC6 >> i), 1, 1'b0, 8'hC6);
    @(negedge clk); loN = 1'b0;
    @(negedge clk); loN = 1'b1;
    @(negedge clk); hiN = 1'b0;
    @(negedge clk);
    chk(wordValid == 1 && wordOut == 8'hC6, "R7 word before collision", {wordValid, wordOut}, {1'b1, 8'hC6});
    hiN = 1'b1; loN = 1'b0;
    @(negedge clk);
    chk(wordValid == 0 && bitClk == 1 && serialBit == 0, "R8 next bit opens with strobe drop",
        {wordValid, bitClk, serialBit}, 3'b010);
    loN = 1'b1;
    @(negedge clk); hiN = 1'b0;
    @(negedge clk); hiN = 1'b1;
    for (int i = 6; i >= 0; i--) sendBit(1'(8'h1E >> i), 1, i == 0, 8'h1E);

    // R9: reset mid-word and mid-pair
    for (int i = 7; i >= 5; i--) sendBit(1'(8'hFF >> i), 1, 1'b0, 8'hFF);
    @(negedge clk); hiN = 1'b0;
    @(negedge clk); rst = 1'b1; hiN = 1'b1;
    @(negedge clk);
    chk(bitClk == 0 && wordValid == 0 && wordOut == 0, "R9 reset clears", {bitClk, wordValid, wordOut}, 0);
    rst = 1'b0;
    sendWord(8'h96, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule